// File: doc/BRIEF.md
# Sensor Code Calibration Converter

This block translates between the raw codes produced by an on-die thermal sensor and temperatures in whole degrees Celsius, in either direction. Its calibration comes from a factory trim word. A load strobe captures that word once. The block then pulls out two trim codes, one for each of two calibration points at 25 and 85 degrees. It checks the first code against a configured window and replaces a bad code with a default fuse value.

After loading, each operand presented with a strobe is converted. One-point mode applies a plain offset correction. Two-point mode interpolates linearly between the two calibration points, and a mode bit in the trim word chooses between the two modes. The offset path gives its result one cycle after acceptance. The interpolating path uses a shared bit-serial divider and holds `busy` while it works. The result is a signed value with a valid strobe.

Top module: `thermcal_conv`

## Requirements
- R1: On `load_trim`, the first trim code is taken from `trim_word[CODE_W-1:0]`. If it is zero, below `lim_min` or above `lim_max`, it is replaced by `fuse_word[7:0]`.
- R2: On `load_trim`, the second trim code is taken from `trim_word[15:8]`. If it is zero, it is replaced by `fuse_word[15:8]`. Any other value is kept, even one outside the `lim_min`..`lim_max` window.
- R3: `trim_word[23]` selects two-point mode when 1 and one-point mode when 0. After reset the mode is one-point and both trim codes are 0.
- R4: `sensor_id` shows `trim_word[19:16]` from the latest load, and 0 after reset.
- R5: In one-point mode, code = temp + trim1 - 25 and temp = code - trim1 + 25.
- R6: In two-point mode, code = (temp - 25) * (trim2 - trim1) / 60 + trim1 and temp = (code - trim1) * 60 / (trim2 - trim1) + 25. The division truncates toward zero.
- R7: In two-point mode with trim2 equal to trim1, the one-point formulas are used.
- R8: Operands and results are signed two's complement, so temperatures below 25 and below 0 convert correctly.
- R9: An operand is accepted when `op_valid` is high and `busy` is low. A one-point result is valid in the cycle after acceptance. A two-point result holds `busy` high until the divider finishes and is valid one cycle after that. Each accepted operand yields exactly one `res_valid` cycle, and an `op_valid` raised while `busy` is high produces no result.
- R10: `op_dir` = 1 converts a temperature to a code, and `op_dir` = 0 converts a code to a temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_trim | input | 1 | Capture and sanitize the trim word |
| trim_word | input | TRIM_W | Factory trim word |
| fuse_word | input | FUSE_W | Default trim codes: low byte first point, high byte second point |
| lim_min | input | CODE_W | Lowest acceptable first trim code |
| lim_max | input | CODE_W | Highest acceptable first trim code |
| op_valid | input | 1 | Operand strobe |
| op_dir | input | 1 | 1: temperature to code, 0: code to temperature |
| op_value | input | VAL_W | Signed operand |
| busy | output | 1 | Division in progress; new operands are ignored |
| res_valid | output | 1 | Result strobe |
| res_value | output | VAL_W | Signed converted value |
| sensor_id | output | 4 | Sensor identifier from the trim word |

## Verification
The hardest situation to reach is an operand arriving while a two-point division is still running. The ports give no direct way to aim at the middle of that window. The stimulus starts an interpolating conversion and waits until `busy` is seen high. It then holds `op_valid` high with a different operand for several cycles. The scoreboard must then receive exactly one result, the one for the first operand. Negative products exercise truncation toward zero. Trim words with a zero, an undersized, an oversized and an equal-pair code drive the fallback paths.

// File: rtl/thermcal_pkg.sv
package thermcal_pkg;
  localparam int REF_LO   = 25;
  localparam int REF_HI   = 85;
  localparam int REF_SPAN = REF_HI - REF_LO;

  typedef enum logic {ST_IDLE, ST_DIV} conv_state_e;

  // offset-only correction
  function automatic int one_pt_code(int t, int t1);
    return t + t1 - REF_LO;
  endfunction

  function automatic int one_pt_temp(int c, int t1);
    return c - t1 + REF_LO;
  endfunction

  // dividends of the interpolating path
  function automatic int span_num_code(int t, int t1, int t2);
    return (t - REF_LO) * (t2 - t1);
  endfunction

  function automatic int span_num_temp(int c, int t1);
    return (c - t1) * REF_SPAN;
  endfunction
endpackage

// File: rtl/thermcal_trim.sv
module thermcal_trim #(
  parameter int CODE_W = 8,
  parameter int TRIM_W = 32,
  parameter int FUSE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TRIM_W-1:0] trim_word,
  input  logic [FUSE_W-1:0] fuse_word,
  input  logic [CODE_W-1:0] lim_min,
  input  logic [CODE_W-1:0] lim_max,
  output logic [CODE_W-1:0] trim1,
  output logic [CODE_W-1:0] trim2,
  output logic              two_pt,
  output logic [3:0]        sensor_id
);
  localparam int SEC_LSB  = 8;
  localparam int SEC_W    = 8;
  localparam int ID_LSB   = 16;
  localparam int ID_W     = 4;
  localparam int MODE_BIT = 23;

  logic [CODE_W-1:0] raw1, san1, raw2, san2;
  logic              bad1;
  logic              unused_trim;

  assign raw1 = trim_word[CODE_W-1:0];
  assign bad1 = (raw1 == '0) || (raw1 < lim_min) || (raw1 > lim_max);
  assign san1 = bad1 ? CODE_W'(fuse_word[SEC_W-1:0]) : raw1;

  assign raw2 = CODE_W'(trim_word[SEC_LSB +: SEC_W]);
  assign san2 = (raw2 == '0) ? CODE_W'(fuse_word[SEC_LSB +: SEC_W]) : raw2;

  assign unused_trim = ^{trim_word[TRIM_W-1:MODE_BIT+1],
                         trim_word[MODE_BIT-1:ID_LSB+ID_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim1     <= '0;
      trim2     <= '0;
      two_pt    <= 1'b0;
      sensor_id <= '0;
    end else if (load) begin
      trim1     <= san1;
      trim2     <= san2;
      two_pt    <= trim_word[MODE_BIT];
      sensor_id <= trim_word[ID_LSB +: ID_W];
    end
  end

  assert_trim1_sane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (trim1 == CODE_W'($past(fuse_word[SEC_W-1:0])) ||
              (trim1 != '0 && trim1 >= $past(lim_min) && trim1 <= $past(lim_max))));

  assert_trim2_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (trim2 != '0 || $past(fuse_word[SEC_LSB +: SEC_W]) == '0));

  assert_mode_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (two_pt == $past(trim_word[MODE_BIT])));

  assert_sensor_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sensor_id));
endmodule

// File: rtl/thermcal_div.sv
module thermcal_div #(
  parameter int NUM_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [NUM_W-1:0] num,
  input  logic signed [NUM_W-1:0] den,
  output logic                    run,
  output logic                    done,
  output logic signed [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] rem_q, quo_q, dvs_q;
  logic [NUM_W-1:0] mag_num, mag_den;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q;
  logic [NUM_W:0]   rem_sh, rem_sub;
  logic             take;

  assign mag_num = num[NUM_W-1] ? $unsigned(-num) : $unsigned(num);
  assign mag_den = den[NUM_W-1] ? $unsigned(-den) : $unsigned(den);
  assign rem_sh  = {rem_q, quo_q[NUM_W-1]};
  assign rem_sub = rem_sh - {1'b0, dvs_q};
  assign take    = rem_sh >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      neg_q <= 1'b0;
      cnt_q <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      rem_q <= '0;
      quo_q <= mag_num;
      dvs_q <= mag_den;
      neg_q <= num[NUM_W-1] ^ den[NUM_W-1];
      cnt_q <= CNT_W'(NUM_W);
      run   <= 1'b1;
      done  <= 1'b0;
    end else if (run) begin
      rem_q <= take ? rem_sub[NUM_W-1:0] : rem_sh[NUM_W-1:0];
      quo_q <= {quo_q[NUM_W-2:0], take};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // truncation toward zero: magnitude quotient, sign applied afterwards
  assign quo = neg_q ? -$signed(quo_q) : $signed(quo_q);

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run);

  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/thermcal_conv.sv
module thermcal_conv #(
  parameter int CODE_W = 8,
  parameter int VAL_W  = 16,
  parameter int NUM_W  = 32,
  parameter int TRIM_W = 32,
  parameter int FUSE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_trim,
  input  logic [TRIM_W-1:0]       trim_word,
  input  logic [FUSE_W-1:0]       fuse_word,
  input  logic [CODE_W-1:0]       lim_min,
  input  logic [CODE_W-1:0]       lim_max,
  input  logic                    op_valid,
  input  logic                    op_dir,
  input  logic signed [VAL_W-1:0] op_value,
  output logic                    busy,
  output logic                    res_valid,
  output logic signed [VAL_W-1:0] res_value,
  output logic [3:0]              sensor_id
);
  import thermcal_pkg::*;

  logic [CODE_W-1:0]       trim1, trim2;
  logic                    two_pt;
  conv_state_e             st_q;
  logic                    accept, use_div, div_start, div_run, div_done;
  logic signed [NUM_W-1:0] div_quo;
  int                      v_i, t1_i, t2_i, one_res, num_i, den_i, off_i, off_q;

  thermcal_trim #(.CODE_W(CODE_W), .TRIM_W(TRIM_W), .FUSE_W(FUSE_W)) trim_i (
    .clk(clk), .rst_n(rst_n), .load(load_trim), .trim_word(trim_word),
    .fuse_word(fuse_word), .lim_min(lim_min), .lim_max(lim_max),
    .trim1(trim1), .trim2(trim2), .two_pt(two_pt), .sensor_id(sensor_id)
  );

  assign busy      = (st_q == ST_DIV);
  assign accept    = op_valid && !busy;
  assign use_div   = two_pt && (trim1 != trim2);
  assign div_start = accept && use_div;

  always_comb begin
    v_i     = int'(op_value);
    t1_i    = int'(trim1);
    t2_i    = int'(trim2);
    one_res = op_dir ? one_pt_code(v_i, t1_i) : one_pt_temp(v_i, t1_i);
    num_i   = op_dir ? span_num_code(v_i, t1_i, t2_i) : span_num_temp(v_i, t1_i);
    den_i   = op_dir ? REF_SPAN : (t2_i - t1_i);
    off_i   = op_dir ? t1_i : REF_LO;
  end

  thermcal_div #(.NUM_W(NUM_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(NUM_W'(num_i)), .den(NUM_W'(den_i)),
    .run(div_run), .done(div_done), .quo(div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      res_valid <= 1'b0;
      res_value <= '0;
      off_q     <= 0;
    end else begin
      res_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (use_div) begin
            st_q  <= ST_DIV;
            off_q <= off_i;
          end else begin
            res_value <= VAL_W'(one_res);
            res_valid <= 1'b1;
          end
        end
        ST_DIV: if (div_done) begin
          res_value <= VAL_W'(int'(div_quo) + off_q);
          res_valid <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_result_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(accept && !use_div) || $past(div_done)));

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_done) |=> busy);

  assert_busy_has_divider_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_run || div_done));
endmodule

// File: tb/thermcal_conv_tb_top.sv
module thermcal_conv_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_trim = 1'b0;
  logic [31:0]       trim_word = '0;
  logic [15:0]       fuse_word = '0;
  logic [7:0]        lim_min = '0;
  logic [7:0]        lim_max = '0;
  logic              op_valid = 1'b0;
  logic              op_dir = 1'b0;
  logic signed [15:0] op_value = '0;
  logic              busy, res_valid;
  logic signed [15:0] res_value;
  logic [3:0]        sensor_id;

  int n_chk = 0, n_fail = 0, n_res = 0, n_push = 0;
  bit finished = 1'b0;
  int exp_q[$];
  string tag_q[$];
  int m_t1 = 0, m_t2 = 0;
  bit m_two = 1'b0;

  always #4 clk = ~clk;

  thermcal_conv dut_i (
    .clk(clk), .rst_n(rst_n), .load_trim(load_trim), .trim_word(trim_word),
    .fuse_word(fuse_word), .lim_min(lim_min), .lim_max(lim_max),
    .op_valid(op_valid), .op_dir(op_dir), .op_value(op_value),
    .busy(busy), .res_valid(res_valid), .res_value(res_value),
    .sensor_id(sensor_id)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // sign-magnitude division, truncating toward zero
  function automatic int tdiv(int a, int b);
    int qa;
    qa = (a < 0 ? -a : a) / (b < 0 ? -b : b);
    return ((a < 0) != (b < 0)) ? -qa : qa;
  endfunction

  function automatic int model(bit dir, int v);
    int r;
    if (m_two && m_t1 != m_t2)
      r = dir ? m_t1 + tdiv((v - 25) * (m_t2 - m_t1), 60)
              : 25 + tdiv((v - m_t1) * 60, m_t2 - m_t1);
    else
      r = dir ? v - 25 + m_t1 : v + 25 - m_t1;
    return int'($signed(r[15:0]));
  endfunction

  // monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      n_res++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected result", int'(res_value), 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(res_value) == e, t, int'(res_value), e);
      end
    end
  end

  task automatic load(bit two, logic [3:0] id, int t2raw, int t1raw,
                      int fuse_hi, int fuse_lo, int lo, int hi);
    int t1, t2;
    @(negedge clk);
    trim_word = {8'h00, two, 3'b000, id, 8'(t2raw), 8'(t1raw)};
    fuse_word = {8'(fuse_hi), 8'(fuse_lo)};
    lim_min   = 8'(lo);
    lim_max   = 8'(hi);
    load_trim = 1'b1;
    @(negedge clk);
    load_trim = 1'b0;
    t1 = t1raw;
    if (t1raw == 0 || t1raw < lo || t1raw > hi) t1 = fuse_lo;
    t2 = (t2raw == 0) ? fuse_hi : t2raw;
    m_t1 = t1; m_t2 = t2; m_two = two;
    check(sensor_id == id, "R4 sensor id after load", int'(sensor_id), int'(id));
  endtask

  task automatic run_op(bit dir, int v, string tag);
    exp_q.push_back(model(dir, v));
    tag_q.push_back(tag);
    n_push++;
    op_valid = 1'b1;
    op_dir   = dir;
    op_value = 16'(v);
    @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R9 reset res_valid", int'(res_valid), 0);
    check(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    check(sensor_id == 4'd0, "R4 reset sensor id", int'(sensor_id), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: reset state is one-point with zero trims
    run_op(1'b1, 30, "R3 reset temp->code");
    run_op(1'b0, 50, "R3 reset code->temp");

    // R1/R5/R8/R10: valid first code, one-point
    load(1'b0, 4'hA, 77, 60, 90, 50, 40, 100);
    run_op(1'b1, 40, "R5 one-point temp->code");
    run_op(1'b0, 80, "R5 one-point code->temp");
    run_op(1'b1, 10, "R8 below 25 temp->code");
    run_op(1'b1, -20, "R8 negative temp->code");
    run_op(1'b0, 30, "R8 negative result code->temp");

    // R1: first code below min, zero, above max -> fuse low byte
    load(1'b0, 4'h3, 0, 30, 90, 50, 40, 100);
    run_op(1'b1, 25, "R1 below-min fallback");
    load(1'b0, 4'h5, 0, 0, 90, 52, 40, 100);
    run_op(1'b0, 70, "R1 zero fallback");
    load(1'b0, 4'h6, 0, 120, 90, 47, 40, 100);
    run_op(1'b1, 60, "R1 above-max fallback");

    // R6: two-point interpolation with truncation toward zero
    load(1'b1, 4'h9, 90, 50, 99, 55, 40, 100);
    run_op(1'b1, 70, "R6 two-point temp->code");
    run_op(1'b1, 0, "R6 negative truncation temp->code");
    run_op(1'b0, 47, "R6 negative truncation code->temp");
    run_op(1'b0, 100, "R6 two-point code->temp");
    run_op(1'b1, -40, "R8 two-point cold temp->code");

    // R2: zero second code -> fuse high byte; out-of-window code kept
    load(1'b1, 4'h1, 0, 50, 100, 55, 40, 100);
    run_op(1'b0, 75, "R2 zero second code fallback");
    load(1'b1, 4'h2, 200, 50, 100, 55, 40, 100);
    run_op(1'b1, 85, "R2 second code not range checked");
    run_op(1'b0, 125, "R2 wide span code->temp");

    // R7: equal trims in two-point mode
    load(1'b1, 4'h7, 70, 70, 100, 55, 40, 100);
    run_op(1'b1, 50, "R7 equal trims temp->code");
    check(busy == 1'b0, "R7 no division for equal trims", int'(busy), 0);
    run_op(1'b0, 90, "R7 equal trims code->temp");

    // R9: operand during a division is ignored
    load(1'b1, 4'hC, 110, 50, 100, 55, 40, 100);
    exp_q.push_back(model(1'b1, 33));
    tag_q.push_back("R9 busy op result");
    n_push++;
    op_valid = 1'b1; op_dir = 1'b1; op_value = 16'sd33;
    @(negedge clk);
    check(busy == 1'b1, "R9 busy after two-point accept", int'(busy), 1);
    op_value = 16'sd99;
    repeat (3) @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_res == n_push, "R9 one result per accepted op", n_res, n_push);
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule